// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Packed-Decimal Arithmetic

This block is the arithmetic and logic unit of an 8-bit accumulator machine. Each accepted request carries an operation code, a register operand (the accumulator or an index register), a memory operand and the current status byte. It produces an 8-bit result and a new status byte. Only the sign, overflow, zero and carry flags change, and each operation updates only its own subset of them. The surrounding sequencer handles instruction fetch, address generation and cycle counting. It also routes the accumulator onto the memory operand port when a shift, rotate or step acts on the accumulator.

Add-with-carry and subtract-with-borrow run in binary, or in packed decimal when the decimal flag of the incoming status byte is set and the `DECIMAL_EN` parameter is 1. In subtraction the borrow is the complement of the carry. The block registers its output once: a request presented with `in_valid` high appears on the outputs after the next rising clock edge. The outputs then hold until the next request.

Status byte bit positions: sign N = bit 7, overflow V = bit 6, break = bit 4, decimal D = bit 3, interrupt mask = bit 2, zero Z = bit 1, carry C = bit 0.

Operation codes on `op_sel`: 0 add, 1 subtract, 2 compare, 3 AND, 4 OR, 5 XOR, 6 shift left, 7 shift right, 8 rotate left, 9 rotate right, 10 increment, 11 decrement, 12 bit test, 13 pass/load, 14 and 15 unused.

Top module: `alu8_core`

## Requirements
- R1: Binary add (op 0, D clear) gives result = (reg + mem + C) mod 256. C is set when the true sum exceeds 255. V is set when the signed sum lies outside -128..127. N and Z follow the result.
- R2: Binary subtract (op 1, D clear) uses borrow = NOT C and gives result = (reg - mem - borrow) mod 256. C is set when reg >= mem + borrow. V is set on signed overflow. N and Z follow the result.
- R3: Decimal add (op 0, D set, valid BCD operands) gives the packed BCD form of (reg + mem + C) mod 100. C and V are both set when the decimal sum exceeds 99.
- R4: Decimal subtract (op 1, D set, valid BCD operands) gives the packed BCD form of (reg - mem - borrow) mod 100. C is set when no borrow occurred, and V is set when it did.
- R5: Compare (op 2) returns reg unchanged. It sets C when mem <= reg and takes N and Z from (reg - mem) mod 256. V is left unchanged.
- R6: AND, OR and XOR (ops 3, 4, 5) combine reg with mem and update only N and Z.
- R7: Shift left (op 6) moves mem bit 7 into C and fills bit 0 with 0. Shift right (op 7) moves mem bit 0 into C and fills bit 7 with 0. N and Z follow the result.
- R8: Rotate left (op 8) moves the old C into bit 0 and mem bit 7 into C. Rotate right (op 9) moves the old C into bit 7 and mem bit 0 into C.
- R9: Increment and decrement (ops 10, 11) of mem wrap modulo 256 and update only N and Z.
- R10: Bit test (op 12) sets Z when (reg AND mem) is 0, copies mem bit 7 into N and mem bit 6 into V, leaves C unchanged, and returns reg.
- R11: Status bits 5 down to 2 (including break, decimal and interrupt mask) pass from the request to `stat_out` unchanged for every operation.
- R12: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While `in_valid` is low, `res_out` and `stat_out` keep their values.
- R13: During reset, `out_valid`, `res_out` and `stat_out` are all 0.
- R14: Pass (op 13) returns mem and updates N and Z. Unused codes 14 and 15 return reg with the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op_sel | input | 4 | Operation code |
| reg_in | input | 8 | Accumulator or index register operand |
| mem_in | input | 8 | Memory or immediate operand |
| stat_in | input | 8 | Current status byte |
| out_valid | output | 1 | Registered result valid |
| res_out | output | 8 | Registered 8-bit result |
| stat_out | output | 8 | Registered updated status byte |

## Verification
The assertions assume that `in_valid`, `op_sel` and the operands are stable and known at each rising edge while reset is released. They also assume that reset is held long enough for the bench to drive inputs low before the first sampled edge. The bench changes inputs only on falling edges and holds `in_valid` low through reset. Decimal checks use only valid BCD digit pairs, because out-of-range digits yield a defined but unspecified value. The hold checks change every operand while `in_valid` is low, so any leak through the output register becomes visible.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned DW = 8;

    // status byte bit positions
    localparam int unsigned FL_N = 7;
    localparam int unsigned FL_V = 6;
    localparam int unsigned FL_D = 3;
    localparam int unsigned FL_Z = 1;
    localparam int unsigned FL_C = 0;

    typedef enum logic [3:0] {
        OP_ADC  = 4'd0,
        OP_SBC  = 4'd1,
        OP_CMP  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_SHL  = 4'd6,
        OP_SHR  = 4'd7,
        OP_ROL  = 4'd8,
        OP_ROR  = 4'd9,
        OP_INC  = 4'd10,
        OP_DEC  = 4'd11,
        OP_BIT  = 4'd12,
        OP_PASS = 4'd13
    } alu_op_e;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] res;
        logic [DW-1:0] st;
    } alu_reg_t;

endpackage

// File: rtl/alu8_binarith.sv
// Binary add / subtract. Subtract is add of the inverted operand, so the
// carry in acts as NOT borrow and the carry out as NOT borrow-out.
module alu8_binarith
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  logic          sub_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o,
    output logic          ovf_o
);
    logic [DW-1:0] b_eff;
    logic [DW:0]   wide;

    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        wide   = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin_i};
        sum_o  = wide[DW-1:0];
        cout_o = wide[DW];
        ovf_o  = (a_i[DW-1] == b_eff[DW-1]) && (sum_o[DW-1] != a_i[DW-1]);
    end
endmodule

// File: rtl/alu8_decarith.sv
// Packed-decimal add / subtract on two-digit operands. Digits are turned
// into a binary value 0..165, combined, folded into 0..99 and repacked.
// Out-of-range digits still give a fixed, bounded result.
module alu8_decarith
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  logic          sub_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o
);
    localparam int unsigned VW = 11;

    logic signed [VW-1:0] av, bv, raw, fold;
    logic [6:0]           mag;
    logic [6:0]           tens, ones;

    always_comb begin
        av = $signed({7'd0, a_i[7:4]}) * 11'sd10 + $signed({7'd0, a_i[3:0]});
        bv = $signed({7'd0, b_i[7:4]}) * 11'sd10 + $signed({7'd0, b_i[3:0]});
        if (sub_i) begin
            raw    = av - bv - $signed({10'd0, ~cin_i});
            cout_o = (raw >= 0);
        end else begin
            raw    = av + bv + $signed({10'd0, cin_i});
            cout_o = (raw > 11'sd99);
        end
        if      (raw >= 11'sd300) fold = raw - 11'sd300;
        else if (raw >= 11'sd200) fold = raw - 11'sd200;
        else if (raw >= 11'sd100) fold = raw - 11'sd100;
        else if (raw < -11'sd100) fold = raw + 11'sd200;
        else if (raw < 0)         fold = raw + 11'sd100;
        else                      fold = raw;
        mag   = fold[6:0];
        tens  = mag / 7'd10;
        ones  = mag % 7'd10;
        sum_o = {tens[3:0], ones[3:0]};
    end
endmodule

// File: rtl/alu8_logicu.sv
// Bitwise, shift, rotate, step and pass operations. Returns the result and
// the carry a shift or rotate produces (otherwise the carry in).
module alu8_logicu
    import alu8_pkg::*;
(
    input  alu_op_e       op_i,
    input  logic [DW-1:0] r_i,
    input  logic [DW-1:0] m_i,
    input  logic          cin_i,
    output logic [DW-1:0] res_o,
    output logic          cout_o
);
    always_comb begin
        res_o  = m_i;
        cout_o = cin_i;
        unique case (op_i)
            OP_AND: res_o = r_i & m_i;
            OP_OR:  res_o = r_i | m_i;
            OP_XOR: res_o = r_i ^ m_i;
            OP_SHL: begin res_o = {m_i[DW-2:0], 1'b0};  cout_o = m_i[DW-1]; end
            OP_SHR: begin res_o = {1'b0, m_i[DW-1:1]};  cout_o = m_i[0];    end
            OP_ROL: begin res_o = {m_i[DW-2:0], cin_i}; cout_o = m_i[DW-1]; end
            OP_ROR: begin res_o = {cin_i, m_i[DW-1:1]}; cout_o = m_i[0];    end
            OP_INC: res_o = m_i + 1'b1;
            OP_DEC: res_o = m_i - 1'b1;
            default: res_o = m_i;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter bit DECIMAL_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    op_sel,
    input  logic [DW-1:0] reg_in,
    input  logic [DW-1:0] mem_in,
    input  logic [DW-1:0] stat_in,
    output logic          out_valid,
    output logic [DW-1:0] res_out,
    output logic [DW-1:0] stat_out
);
    alu_op_e       op;
    logic          arith_sub, arith_cin;
    logic [DW-1:0] bin_sum, dec_sum, lu_res;
    logic          bin_c, bin_v, dec_c, lu_c, dec_sel;
    alu_reg_t      nxt_d, cur_q;

    assign op        = alu_op_e'(op_sel);
    assign arith_sub = (op != OP_ADC);
    assign arith_cin = (op == OP_CMP) ? 1'b1 : stat_in[FL_C];

    alu8_binarith u_bin (
        .a_i(reg_in), .b_i(mem_in), .cin_i(arith_cin), .sub_i(arith_sub),
        .sum_o(bin_sum), .cout_o(bin_c), .ovf_o(bin_v)
    );

    generate
        if (DECIMAL_EN) begin : g_dec
            alu8_decarith u_dec (
                .a_i(reg_in), .b_i(mem_in), .cin_i(stat_in[FL_C]), .sub_i(arith_sub),
                .sum_o(dec_sum), .cout_o(dec_c)
            );
            assign dec_sel = stat_in[FL_D];
        end else begin : g_nodec
            assign dec_sum = '0;
            assign dec_c   = 1'b0;
            assign dec_sel = 1'b0;
        end
    endgenerate

    alu8_logicu u_lu (
        .op_i(op), .r_i(reg_in), .m_i(mem_in), .cin_i(stat_in[FL_C]),
        .res_o(lu_res), .cout_o(lu_c)
    );

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.vld = in_valid;
        if (in_valid) begin
            nxt_d.res = reg_in;
            nxt_d.st  = stat_in;
            unique case (op)
                OP_ADC, OP_SBC: begin
                    if (dec_sel) begin
                        nxt_d.res      = dec_sum;
                        nxt_d.st[FL_C] = dec_c;
                        nxt_d.st[FL_V] = (op == OP_ADC) ? dec_c : ~dec_c;
                    end else begin
                        nxt_d.res      = bin_sum;
                        nxt_d.st[FL_C] = bin_c;
                        nxt_d.st[FL_V] = bin_v;
                    end
                    nxt_d.st[FL_N] = nxt_d.res[DW-1];
                    nxt_d.st[FL_Z] = (nxt_d.res == '0);
                end
                OP_CMP: begin
                    nxt_d.st[FL_C] = bin_c;
                    nxt_d.st[FL_N] = bin_sum[DW-1];
                    nxt_d.st[FL_Z] = (bin_sum == '0);
                end
                OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_PASS,
                OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                    nxt_d.res      = lu_res;
                    nxt_d.st[FL_C] = lu_c;
                    nxt_d.st[FL_N] = lu_res[DW-1];
                    nxt_d.st[FL_Z] = (lu_res == '0);
                end
                OP_BIT: begin
                    nxt_d.st[FL_Z] = ((reg_in & mem_in) == '0);
                    nxt_d.st[FL_N] = mem_in[DW-1];
                    nxt_d.st[FL_V] = mem_in[DW-2];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign out_valid = cur_q.vld;
    assign res_out   = cur_q.res;
    assign stat_out  = cur_q.st;

    // R12: a request is answered in the very next cycle, and only then
    p_valid_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(res_out) && $stable(stat_out)));
    // R11: control bits of the status byte are carried through
    p_ctrl_passthru_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (stat_out[5:2] == $past(stat_in[5:2])));
    // R5: compare leaves the register value and overflow untouched
    p_cmp_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd2) |=>
            (res_out == $past(reg_in) && stat_out[FL_V] == $past(stat_in[FL_V])));
    // R10: bit test loads sign and overflow from the operand
    p_bit_nv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd12) |=>
            (stat_out[7:6] == $past(mem_in[7:6]) && stat_out[FL_C] == $past(stat_in[FL_C])));
    // R9: steps never touch carry or overflow
    p_step_cv_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_sel == 4'd10 || op_sel == 4'd11)) |=>
            (stat_out[FL_V] == $past(stat_in[FL_V]) && stat_out[FL_C] == $past(stat_in[FL_C])));
endmodule

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] reg_in = '0, mem_in = '0, stat_in = '0;
    logic       out_valid;
    logic [7:0] res_out, stat_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alu8_core u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .reg_in(reg_in), .mem_in(mem_in), .stat_in(stat_in),
        .out_valid(out_valid), .res_out(res_out), .stat_out(stat_out)
    );

    // {req, op, reg, mem, stat_in, exp_res, exp_stat}
    localparam int NV = 29;
    localparam logic [47:0] VEC [NV] = '{
        {4'd1, 4'd0,  8'h50, 8'h50, 8'h20, 8'hA0, 8'hE0}, // R1 signed overflow
        {4'd1, 4'd0,  8'hFF, 8'h01, 8'h21, 8'h01, 8'h21}, // R1 carry out
        {4'd1, 4'd0,  8'h80, 8'h80, 8'h24, 8'h00, 8'h67}, // R1 zero, C, V
        {4'd2, 4'd1,  8'h50, 8'h30, 8'h21, 8'h20, 8'h21}, // R2 no borrow
        {4'd2, 4'd1,  8'h50, 8'hB0, 8'h21, 8'hA0, 8'hE0}, // R2 overflow
        {4'd2, 4'd1,  8'h00, 8'h00, 8'h20, 8'hFF, 8'hA0}, // R2 borrow in
        {4'd3, 4'd0,  8'h58, 8'h46, 8'h28, 8'h04, 8'h69}, // R3 exceeds 99
        {4'd3, 4'd0,  8'h12, 8'h34, 8'h29, 8'h47, 8'h28}, // R3 carry in
        {4'd3, 4'd0,  8'h99, 8'h00, 8'h29, 8'h00, 8'h6B}, // R3 wrap to zero
        {4'd4, 4'd1,  8'h46, 8'h12, 8'h29, 8'h34, 8'h29}, // R4 plain
        {4'd4, 4'd1,  8'h12, 8'h21, 8'h29, 8'h91, 8'hE8}, // R4 borrow out
        {4'd4, 4'd1,  8'h00, 8'h00, 8'h28, 8'h99, 8'hE8}, // R4 borrow in
        {4'd5, 4'd2,  8'h40, 8'h40, 8'h60, 8'h40, 8'h63}, // R5 equal
        {4'd5, 4'd2,  8'h10, 8'h20, 8'h21, 8'h10, 8'hA0}, // R5 less
        {4'd6, 4'd3,  8'hF0, 8'h0F, 8'hC1, 8'h00, 8'h43}, // R6 AND
        {4'd6, 4'd4,  8'h80, 8'h01, 8'h02, 8'h81, 8'h80}, // R6 OR
        {4'd6, 4'd5,  8'hFF, 8'h0F, 8'h00, 8'hF0, 8'h80}, // R6 XOR
        {4'd7, 4'd6,  8'h00, 8'h81, 8'h20, 8'h02, 8'h21}, // R7 shift left
        {4'd7, 4'd7,  8'h00, 8'h81, 8'hA0, 8'h40, 8'h21}, // R7 shift right
        {4'd8, 4'd8,  8'h00, 8'h80, 8'h21, 8'h01, 8'h21}, // R8 rotate left
        {4'd8, 4'd9,  8'h00, 8'h01, 8'h21, 8'h80, 8'hA1}, // R8 rotate right
        {4'd8, 4'd9,  8'h00, 8'h01, 8'h20, 8'h00, 8'h23}, // R8 rotate to zero
        {4'd9, 4'd10, 8'h00, 8'hFF, 8'h61, 8'h00, 8'h63}, // R9 inc wrap
        {4'd9, 4'd11, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h80}, // R9 dec wrap
        {4'd10,4'd12, 8'h0F, 8'hC0, 8'h01, 8'h0F, 8'hC3}, // R10 disjoint
        {4'd10,4'd12, 8'h01, 8'h01, 8'hC2, 8'h01, 8'h00}, // R10 overlap
        {4'd14,4'd13, 8'h77, 8'h00, 8'h9C, 8'h00, 8'h1E}, // R14 pass
        {4'd14,4'd15, 8'h5A, 8'h33, 8'hD5, 8'h5A, 8'hD5}, // R14 unused code
        {4'd11,4'd3,  8'hFF, 8'h3C, 8'h0C, 8'h3C, 8'h0C}  // R11 D and I kept
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] held_res, held_st;
        repeat (3) @(negedge clk);
        // R13: reset state
        chk("R13 valid", {7'd0, out_valid}, 8'h00);
        chk("R13 res", res_out, 8'h00);
        chk("R13 stat", stat_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            op_sel   = VEC[i][43:40];
            reg_in   = VEC[i][39:32];
            mem_in   = VEC[i][31:24];
            stat_in  = VEC[i][23:16];
            in_valid = 1'b1;
            @(negedge clk);
            chk($sformatf("R%0d res vec%0d", VEC[i][47:44], i), res_out, VEC[i][15:8]);
            chk($sformatf("R%0d stat vec%0d", VEC[i][47:44], i), stat_out, VEC[i][7:0]);
            chk($sformatf("R12 valid vec%0d", i), {7'd0, out_valid}, 8'h01);
        end

        // R12: idle cycles hold the last result while operands move
        held_res = res_out;
        held_st  = stat_out;
        in_valid = 1'b0;
        op_sel   = 4'd0;
        reg_in   = 8'hFF;
        mem_in   = 8'hFF;
        stat_in  = 8'hFF;
        @(negedge clk);
        chk("R12 idle valid", {7'd0, out_valid}, 8'h00);
        @(negedge clk);
        chk("R12 hold res", res_out, held_res);
        chk("R12 hold stat", stat_out, held_st);

        // R12: back-to-back requests, each answered one cycle later
        op_sel = 4'd10; mem_in = 8'h7F; stat_in = 8'h00; in_valid = 1'b1;
        @(negedge clk);
        chk("R9 inc to sign", res_out, 8'h80);
        chk("R9 inc stat", stat_out, 8'h80);
        op_sel = 4'd1; reg_in = 8'h80; mem_in = 8'h01; stat_in = 8'h01;
        @(negedge clk);
        chk("R2 min minus one", res_out, 8'h7F);
        chk("R2 min minus one stat", stat_out, 8'h41);
        in_valid = 1'b0;

        // R13: reset in mid-run clears the outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R13 re-reset valid", {7'd0, out_valid}, 8'h00);
        chk("R13 re-reset res", res_out, 8'h00);
        chk("R13 re-reset stat", stat_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule